// File: doc/BRIEF.md
# Handshaked Configuration and Result Sequencer for a Key-Search Engine

This block is the control sequencer between a bus-facing pair of FIFOs and a brute-force key-search engine. Software pushes a job into the inbound FIFO as five 32-bit words. The sequencer drains them one at a time with a request/acknowledge handshake and assembles a 64-bit known plaintext, a 64-bit known ciphertext and a 24-bit upper key prefix. It then launches the engine and waits for the engine to report completion.

When the engine finishes, the sequencer forms a 64-bit result. The result is the matching key when one was found and all zeros otherwise. It is pushed into the outbound FIFO as two words with the same kind of handshake. A one-cycle interrupt pulse follows the last word, and the sequencer then waits for the next job. A synchronous soft reset returns it to the waiting state from any point, discards partial input and tells the engine to abandon a search in progress.

Top module: `cmd_sequencer`

## Requirements
- R1: When `rst_n` is released, `wf_req` is 1 and `rf_req`, `irq`, `eng_start` and `eng_abort` are 0.
- R2: Inbound words map in this order: word 0 to `eng_plain[63:32]`, word 1 to `eng_plain[31:0]`, word 2 to `eng_cipher[63:32]`, word 3 to `eng_cipher[31:0]`, and bits 23:0 of word 4 to `eng_hkey`. Bits 31:24 of word 4 are ignored.
- R3: `wf_req` stays high until a word is accepted. Exactly one word is taken in each cycle where `wf_req` and `wf_ack` are both high, and `wf_ack` has no effect while `wf_req` is low.
- R4: `eng_start` is high for exactly one cycle: the cycle after the fifth word is accepted.
- R5: After the start, neither request is raised until a cycle with `eng_done` high. That done cycle must come at least one cycle after the start.
- R6: One cycle after `eng_done` is seen, `rf_req` rises. The result is `eng_key` if `eng_found` is 1 and zero otherwise. It is sent bits 63:32 first and bits 31:0 second.
- R7: `rf_req` and `rf_data` hold steady until `rf_ack`. Each cycle where both are high moves on one word, and `rf_ack` has no effect while `rf_req` is low.
- R8: `irq` is a single-cycle pulse in the cycle after the second result word is accepted. `wf_req` returns to 1 in the cycle after that pulse.
- R9: A cycle with `soft_rst` high sends the block back to waiting for word 0 at the next edge, from any state. Partly received words are discarded. `eng_abort` is high in that cycle if the engine was started and has not reported done.
- R10: `eng_done` has no effect outside the wait for the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| wf_req | output | 1 | Read request to inbound FIFO |
| wf_ack | input | 1 | Inbound word valid and taken |
| wf_data | input | 32 | Inbound word |
| rf_req | output | 1 | Write request to outbound FIFO |
| rf_ack | input | 1 | Outbound word accepted |
| rf_data | output | 32 | Outbound word |
| eng_start | output | 1 | Launch pulse to engine |
| eng_abort | output | 1 | Abandon current search |
| eng_plain | output | 64 | Known plaintext |
| eng_cipher | output | 64 | Known ciphertext |
| eng_hkey | output | 24 | Upper key prefix |
| eng_done | input | 1 | Engine finished |
| eng_found | input | 1 | Engine found a key |
| eng_key | input | 64 | Key found by engine |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Jobs are fed back to back with an acknowledge on every cycle, and again with idle gaps between acknowledges. This separates true request holding from a block that only works at full rate. Found and not-found completions tell the key path apart from the zero path, and delayed outbound acknowledges test that `rf_data` stays stable.

Acknowledges and done pulses are also sent while they should be ignored, and soft resets land mid-input, mid-search and mid-output. These show that stray handshakes, stale partial words and stale results never leak into the next job. A word 4 with nonzero upper bits shows that only the prefix bits are kept.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  typedef enum logic [2:0] {
    ST_LOAD  = 3'd0,
    ST_START = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SEND  = 3'd3,
    ST_IRQ   = 3'd4
  } seq_state_t;

  function automatic int words_in(input int bits, input int word_bits);
    return bits / word_bits;
  endfunction
endpackage

// File: rtl/seq_cfg_collect.sv
`timescale 1ns/1ps
module seq_cfg_collect #(
  parameter int WORD_W = 32,
  parameter int BLK_W  = 64,
  parameter int HKEY_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic [BLK_W-1:0]  plain,
  output logic [BLK_W-1:0]  cipher,
  output logic [HKEY_W-1:0] hkey,
  output logic              last
);
  localparam int PER_BLK = seq_pkg::words_in(BLK_W, WORD_W);
  localparam int NSLOT   = 2 * PER_BLK;
  localparam int TOTAL   = NSLOT + 1;
  localparam int IW      = $clog2(TOTAL);

  logic [WORD_W-1:0] slot [NSLOT];
  logic [HKEY_W-1:0] hkey_q;
  logic [IW-1:0]     idx;

  assign last = take && (idx == IW'(TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      hkey_q <= '0;
      for (int i = 0; i < NSLOT; i++) slot[i] <= '0;
    end else if (clr) begin
      idx    <= '0;
      hkey_q <= '0;
      for (int i = 0; i < NSLOT; i++) slot[i] <= '0;
    end else if (take) begin
      if (last) begin
        hkey_q <= word[HKEY_W-1:0];
        idx    <= '0;
      end else begin
        slot[idx] <= word;
        idx       <= idx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < PER_BLK; g++) begin : g_place
    assign plain [(PER_BLK-1-g)*WORD_W +: WORD_W] = slot[g];
    assign cipher[(PER_BLK-1-g)*WORD_W +: WORD_W] = slot[PER_BLK+g];
  end
  assign hkey = hkey_q;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < TOTAL);  // R2
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0));  // R9
endmodule

// File: rtl/seq_result_send.sv
`timescale 1ns/1ps
module seq_result_send #(
  parameter int WORD_W = 32,
  parameter int BLK_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              found,
  input  logic [BLK_W-1:0]  key,
  input  logic              active,
  input  logic              adv,
  output logic [WORD_W-1:0] word_out,
  output logic              last
);
  localparam int PER_BLK = seq_pkg::words_in(BLK_W, WORD_W);
  localparam int IW      = (PER_BLK > 1) ? $clog2(PER_BLK) : 1;

  logic [BLK_W-1:0] res;
  logic [IW-1:0]    sel;

  function automatic logic [BLK_W-1:0] outcome(input logic hit, input logic [BLK_W-1:0] k);
    return hit ? k : '0;
  endfunction

  function automatic logic [WORD_W-1:0] pick(input logic [BLK_W-1:0] v, input logic [IW-1:0] s);
    return v[(PER_BLK-1-int'(s))*WORD_W +: WORD_W];
  endfunction

  assign last     = adv && (sel == IW'(PER_BLK - 1));
  assign word_out = pick(res, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
      sel <= '0;
    end else if (clr) begin
      res <= '0;
      sel <= '0;
    end else if (load) begin
      res <= outcome(found, key);
      sel <= '0;
    end else if (adv) begin
      sel <= last ? '0 : sel + 1'b1;
    end
  end

  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !adv && !clr) |=> $stable(word_out));  // R7
endmodule

// File: rtl/cmd_sequencer.sv
`timescale 1ns/1ps
module cmd_sequencer #(
  parameter int WORD_W = 32,
  parameter int BLK_W  = 64,
  parameter int HKEY_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  output logic              wf_req,
  input  logic              wf_ack,
  input  logic [WORD_W-1:0] wf_data,
  output logic              rf_req,
  input  logic              rf_ack,
  output logic [WORD_W-1:0] rf_data,
  output logic              eng_start,
  output logic              eng_abort,
  output logic [BLK_W-1:0]  eng_plain,
  output logic [BLK_W-1:0]  eng_cipher,
  output logic [HKEY_W-1:0] eng_hkey,
  input  logic              eng_done,
  input  logic              eng_found,
  input  logic [BLK_W-1:0]  eng_key,
  output logic              irq
);
  import seq_pkg::*;

  seq_state_t state, state_nx;

  // named internal events
  logic cfg_take, cfg_last, res_load, res_adv, res_last, busy;

  assign cfg_take = (state == ST_LOAD) && wf_ack;
  assign res_load = (state == ST_WAIT) && eng_done;
  assign res_adv  = (state == ST_SEND) && rf_ack;
  assign busy     = (state == ST_START) || (state == ST_WAIT);

  seq_cfg_collect #(.WORD_W(WORD_W), .BLK_W(BLK_W), .HKEY_W(HKEY_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .take(cfg_take), .word(wf_data),
    .plain(eng_plain), .cipher(eng_cipher), .hkey(eng_hkey), .last(cfg_last)
  );

  seq_result_send #(.WORD_W(WORD_W), .BLK_W(BLK_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(res_load), .found(eng_found),
    .key(eng_key), .active(state == ST_SEND), .adv(res_adv),
    .word_out(rf_data), .last(res_last)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_LOAD:  if (cfg_last) state_nx = ST_START;
      ST_START: state_nx = ST_WAIT;
      ST_WAIT:  if (res_load) state_nx = ST_SEND;
      ST_SEND:  if (res_last) state_nx = ST_IRQ;
      ST_IRQ:   state_nx = ST_LOAD;
      default:  state_nx = ST_LOAD;
    endcase
    if (soft_rst) state_nx = ST_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOAD;
    else        state <= state_nx;
  end

  assign wf_req    = (state == ST_LOAD);
  assign rf_req    = (state == ST_SEND);
  assign eng_start = (state == ST_START);
  assign irq       = (state == ST_IRQ);
  assign eng_abort = soft_rst && busy;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_req && !wf_ack) |=> wf_req);  // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && !rf_ack && !soft_rst) |=> rf_req);  // R7
  AST_START_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(wf_req && wf_ack));  // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);  // R4
  AST_RESULT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_req) |-> $past(eng_done));  // R6
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rf_req && rf_ack));  // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);  // R8
  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (wf_req && !rf_req && !eng_start && !irq));  // R9
endmodule

// File: tb/sim_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_cmd_sequencer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, soft_rst, wf_ack, rf_ack, eng_done, eng_found;
  logic [31:0] wf_data;
  logic [63:0] eng_key;
  logic        wf_req, rf_req, eng_start, eng_abort, irq;
  logic [31:0] rf_data;
  logic [63:0] eng_plain, eng_cipher;
  logic [23:0] eng_hkey;

  cmd_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wf_req(wf_req), .wf_ack(wf_ack), .wf_data(wf_data),
    .rf_req(rf_req), .rf_ack(rf_ack), .rf_data(rf_data),
    .eng_start(eng_start), .eng_abort(eng_abort),
    .eng_plain(eng_plain), .eng_cipher(eng_cipher), .eng_hkey(eng_hkey),
    .eng_done(eng_done), .eng_found(eng_found), .eng_key(eng_key), .irq(irq)
  );

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 take words, 1 launch, 2 wait, 3 emit, 4 notify
  int          m_phase = 0;
  int          m_got = 0;
  logic [31:0] m_cw [5];
  logic [31:0] m_out [$];

  always @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      m_phase = 0; m_got = 0; m_out.delete();
    end else begin
      case (m_phase)
        0: if (wf_ack) begin
             m_cw[m_got] = wf_data; m_got++;
             if (m_got == 5) begin m_got = 0; m_phase = 1; end
           end
        1: m_phase = 2;
        2: if (eng_done) begin
             m_out.delete();
             if (eng_found) begin m_out.push_back(eng_key[63:32]); m_out.push_back(eng_key[31:0]); end
             else begin m_out.push_back(32'h0); m_out.push_back(32'h0); end
             m_phase = 3;
           end
        3: if (rf_ack) begin
             void'(m_out.pop_front());
             if (m_out.size() == 0) m_phase = 4;
           end
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(m_phase == 2 ? "R5" : "R3", "wf_req", 64'(wf_req), 64'(m_phase == 0));
      chk(m_phase == 2 ? "R5" : "R7", "rf_req", 64'(rf_req), 64'(m_phase == 3));
      chk("R4", "eng_start", 64'(eng_start), 64'(m_phase == 1));
      chk("R8", "irq", 64'(irq), 64'(m_phase == 4));
      chk("R9", "eng_abort", 64'(eng_abort), 64'(soft_rst && (m_phase == 1 || m_phase == 2)));
      if (m_phase == 3) chk("R6", "rf_data", 64'(rf_data), 64'(m_out[0]));
      if (m_phase == 1 || m_phase == 2) begin
        chk("R2", "eng_plain", eng_plain, {m_cw[0], m_cw[1]});
        chk("R2", "eng_cipher", eng_cipher, {m_cw[2], m_cw[3]});
        chk("R2", "eng_hkey", 64'(eng_hkey), 64'(m_cw[4][23:0]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 40000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<40000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic feed(input logic [31:0] w [5], input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        wf_ack = 1'b0; wf_data = 32'hDEAD_0000 + 32'(g); cyc();
      end
      while (!wf_req) cyc();
      wf_ack = 1'b1; wf_data = w[i]; cyc();
      wf_ack = 1'b0;
    end
  endtask

  task automatic finish_job(input logic [31:0] w [5], input logic hit, input logic [63:0] key,
                            input int delay, input int gap);
    logic [31:0] got [2];
    logic [63:0] exp;
    while (!eng_start) cyc();
    chk("R2", "plain at start", eng_plain, {w[0], w[1]});
    chk("R2", "cipher at start", eng_cipher, {w[2], w[3]});
    chk("R2", "hkey upper bits ignored", 64'(eng_hkey), 64'(w[4][23:0]));
    cyc();
    for (int d = 0; d < delay; d++) begin
      wf_ack = 1'b1; wf_data = 32'hBAD0_0000; rf_ack = 1'b1; cyc();  // stray acks, R3 R7
    end
    wf_ack = 1'b0; rf_ack = 1'b0;
    chk("R5", "no request while waiting", 64'({wf_req, rf_req}), 64'(0));
    eng_done = 1'b1; eng_found = hit; eng_key = key; cyc();
    eng_done = 1'b0; eng_found = 1'b0; eng_key = 64'h0123_4567_89AB_CDEF;
    chk("R6", "rf_req after done", 64'(rf_req), 64'(1));
    for (int k = 0; k < 2; k++) begin
      while (!rf_req) cyc();
      for (int g = 0; g < gap; g++) cyc();
      got[k] = rf_data; rf_ack = 1'b1; cyc(); rf_ack = 1'b0;
    end
    exp = hit ? key : 64'h0;
    chk("R6", "result word high", 64'(got[0]), 64'(exp[63:32]));
    chk("R6", "result word low", 64'(got[1]), 64'(exp[31:0]));
    chk("R8", "irq pulse", 64'(irq), 64'(1));
    cyc();
    chk("R8", "back to idle", 64'({irq, wf_req}), 64'(2'b01));
  endtask

  logic [31:0] ja [5], jb [5], jc [5];

  initial begin
    rst_n = 0; soft_rst = 0; wf_ack = 0; rf_ack = 0; eng_done = 0; eng_found = 0;
    wf_data = '0; eng_key = '0;
    ja = '{32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888, 32'hFFAB_CDEF};
    jb = '{32'hCAFE_F00D, 32'h0BAD_BEEF, 32'h1234_5678, 32'h9ABC_DEF0, 32'h00C0_FFEE};
    jc = '{32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h7E12_3456};
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1", "reset outputs", 64'({wf_req, rf_req, irq, eng_start, eng_abort}), 64'(5'b10000));

    // back-to-back acks, key found
    feed(ja, 5, 0);
    finish_job(ja, 1'b1, 64'hFEDC_BA98_7654_3210, 1, 0);

    // gapped acks, not found, delayed outbound acks
    feed(jb, 5, 2);
    finish_job(jb, 1'b0, 64'h1357_9BDF_2468_ACE0, 3, 3);

    // stray done in idle (R10), partial job then soft reset (R9)
    eng_done = 1'b1; eng_found = 1'b1; eng_key = 64'hFFFF_FFFF_FFFF_FFFF; cyc();
    eng_done = 1'b0; eng_found = 1'b0;
    chk("R10", "done ignored in idle", 64'({wf_req, rf_req}), 64'(2'b10));
    feed(ja, 2, 0);
    soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
    chk("R9", "idle after soft reset", 64'(wf_req), 64'(1));
    feed(jc, 5, 1);
    finish_job(jc, 1'b1, 64'h0A0B_0C0D_0E0F_1011, 2, 1);

    // soft reset during search
    feed(jb, 5, 0);
    while (!eng_start) cyc();
    cyc();
    soft_rst = 1'b1; #1;
    chk("R9", "abort during search", 64'(eng_abort), 64'(1));
    cyc(); soft_rst = 1'b0;
    chk("R9", "idle after abort", 64'({wf_req, eng_start}), 64'(2'b10));
    eng_done = 1'b1; eng_found = 1'b1; cyc(); eng_done = 1'b0; eng_found = 1'b0;
    chk("R10", "late done ignored", 64'(rf_req), 64'(0));
    feed(ja, 5, 0);
    finish_job(ja, 1'b0, 64'h0, 1, 0);

    // soft reset during output
    feed(jc, 5, 0);
    while (!eng_start) cyc();
    cyc();
    eng_done = 1'b1; eng_found = 1'b1; eng_key = 64'h1111_1111_2222_2222; cyc(); eng_done = 1'b0;
    rf_ack = 1'b1; cyc(); rf_ack = 1'b0;
    soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
    chk("R9", "output dropped by soft reset", 64'({wf_req, rf_req, irq}), 64'(3'b100));
    feed(jb, 5, 1);
    finish_job(jb, 1'b1, 64'h8000_0000_0000_0001, 2, 2);

    repeat (3) cyc();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule